// File: doc/BRIEF.md
# Transceiver Power-Up and Reset Sequencer

This block runs the start-up of one serial transceiver channel from its reference clock. When the supply-good input rises, the channel is first held in reset for a programmable interval of 15 to 70 µs. It then moves through a fixed timeline, measured in reference-clock ticks. The PLL is first held at minimum frequency so that bias can settle. Next the PLL locks while the receiver analog circuits start to lock. Next the receiver acquires incoming data and finishes locking. Finally the receive word is declared valid and comma detection and word alignment are enabled. Every microsecond value is turned into ticks through a ticks-per-microsecond parameter.

An active-low reset pin can restart the channel at any time. The pin passes through a two-flop synchroniser. A low pulse is accepted only after it has lasted one microsecond of counted ticks. While the reset is accepted, the block forces its control outputs: the PLL runs at minimum frequency, the serial output is held at logic 0, the receive word is frozen, the deserializer clocking is held in reset, the selected recovery phase is cleared and the digital loop filter is cleared. Releasing the pin restarts the timeline from phase zero. A PLL-bypass input and a low-power input keep the timeline parked at phase zero for as long as either is high. The reset pin is meant to carry an external pull-up so that an undriven pin reads as inactive. All pins are plain level signals; no data stream passes through the block.

Top module: `xcvr_pwr_seq`

## Requirements
- R1: While supply_ok is low, the block is in the hold state at once, without waiting for a clock. phase_onehot reads 7'b0000001. pll_force_min, serial_out_zero, rx_word_freeze, deser_clk_rst, phase_sel_clr and dfilt_clr are 1. comma_det_en and rx_valid are 0.
- R2: After supply_ok rises, the hold lasts HOLD_US*TICKS_PER_US counted ticks. The first-phase bit (bit 2) appears HOLD_US*TICKS_PER_US+2 cycles after the rise, the extra 2 cycles coming from the synchroniser.
- R3: Let n be the number of ticks since the timeline entered phase zero. The phase is BIAS (bit 2) for n < PLL_US*T, PLL-lock (bit 3) for n < RXANA_US*T, receiver-analog (bit 4) for n < RXDATA_US*T, receiver-data (bit 5) for n < READY_US*T, and ready (bit 6) from then on, where T is TICKS_PER_US.
- R4: pll_force_min is 1 in the hold, reset and BIAS phases. serial_out_zero, rx_word_freeze, deser_clk_rst, phase_sel_clr and dfilt_clr are 1 exactly in the hold and reset phases.
- R5: comma_det_en and rx_valid are 1 only in the ready phase.
- R6: While pll_bypass or low_power is high (each passes through a 2-flop synchroniser), the running timeline is held at phase zero with n = 0. Once both are low again, the timeline runs from n = 0.
- R7: A low pulse on rst_pin_n covering fewer than RST_MIN_US*T rising clock edges is ignored, and the phase is left unchanged. A pulse covering at least that many edges is accepted, and the reset phase (bit 1) appears RST_MIN_US*T+3 cycles after the pin falls.
- R8: In the reset phase, all forced outputs listed in R4 are 1, and comma_det_en and rx_valid are 0.
- R9: When an accepted reset is released, the reset phase lasts until 3 cycles after the pin rises. Phase zero with n = 0 follows 4 cycles after the rise.
- R10: phase_onehot has exactly one bit set: bit 0 hold, 1 reset, 2 BIAS, 3 PLL-lock, 4 receiver-analog, 5 receiver-data, 6 ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every timed interval is counted in its ticks |
| supply_ok | input | 1 | Supply good, active high; low acts as asynchronous reset of the block |
| rst_pin_n | input | 1 | Channel reset request, active low, asynchronous to clk |
| pll_bypass | input | 1 | PLL bypass request; parks the timeline at phase zero |
| low_power | input | 1 | Low-power request; parks the timeline at phase zero |
| pll_force_min | output | 1 | Holds the PLL VCO at minimum frequency |
| serial_out_zero | output | 1 | Forces the serial transmit output to logic 0 |
| rx_word_freeze | output | 1 | Freezes the parallel receive word |
| deser_clk_rst | output | 1 | Holds the deserializer clocking in reset |
| phase_sel_clr | output | 1 | Clears the selected recovery-clock phase |
| dfilt_clr | output | 1 | Clears the recovery loop's digital filter |
| comma_det_en | output | 1 | Enables comma detection and word alignment |
| rx_valid | output | 1 | Receive word is declared valid |
| phase_onehot | output | 7 | One-hot current phase, encoded as in R10 |

## Verification
The hardest case to reach from the ports is a reset pulse whose length sits right at the acceptance threshold. The synchroniser and the qualification counter add latency, so a pulse one tick shorter than the threshold must leave a ready channel untouched, while a pulse of exactly the threshold must produce a single-cycle reset phase and then a restart. To reach it, the stimulus first brings the channel to ready, then applies directed pulses of threshold and threshold-minus-one length, followed by seeded random lengths around the threshold. After each accepted pulse the stimulus walks the full timeline again tick by tick. A second case is parking by bypass or low power in the middle of a run, and then releasing it.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [1:0] {M_HOLD = 2'd0, M_RST = 2'd1, M_RUN = 2'd2} mode_e;
  localparam int PH_N      = 7;
  localparam int PH_HOLD   = 0;
  localparam int PH_RST    = 1;
  localparam int PH_BIAS   = 2;
  localparam int PH_PLL    = 3;
  localparam int PH_RXANA  = 4;
  localparam int PH_RXDATA = 5;
  localparam int PH_READY  = 6;
endpackage

// File: rtl/xps_sync.sv
module xps_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xps_rst_qual.sv
module xps_rst_qual #(
  parameter int MIN_TICKS = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic low_s,
  output logic accepted
);
  localparam int QW = $clog2(MIN_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(MIN_TICKS);
  logic [QW-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            low_cnt <= '0;
    else if (!low_s)        low_cnt <= '0;
    else if (low_cnt != QMAX) low_cnt <= low_cnt + QW'(1);
  end

  assign accepted = (low_cnt == QMAX);

  // R7
  release_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !low_s |=> !accepted);
endmodule

// File: rtl/xps_timeline.sv
module xps_timeline
  import xps_pkg::*;
#(
  parameter int HOLD_TICKS  = 160,
  parameter int READY_TICKS = 1432,
  parameter int CNT_W       = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sup_s,
  input  logic             gate,
  input  logic             acc,
  output mode_e            mode,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] RDY_CNT   = CNT_W'(READY_TICKS);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode <= M_HOLD;
      cnt  <= '0;
    end else begin
      case (mode)
        M_HOLD: if (sup_s) begin
          if (cnt == HOLD_LAST) begin
            mode <= acc ? M_RST : M_RUN;
            cnt  <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        M_RST: begin
          cnt <= '0;
          if (!acc) mode <= M_RUN;
        end
        default: begin
          if (acc) begin
            mode <= M_RST;
            cnt  <= '0;
          end else if (gate) begin
            cnt <= '0;
          end else if (cnt != RDY_CNT) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == M_RUN && cnt != '0) |->
      ($past(mode) == M_RUN && (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))));

  // R6
  gate_park_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(mode) == M_RUN && $past(gate) && !$past(acc)) |-> (cnt == '0));

  // R9
  rst_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == M_RST) |=> (mode != M_HOLD && cnt == '0));
endmodule

// File: rtl/xps_phase_dec.sv
module xps_phase_dec
  import xps_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int PLL_TICKS   = 128,
  parameter int RXANA_TICKS = 1048,
  parameter int RXDAT_TICKS = 1304,
  parameter int READY_TICKS = 1432
) (
  input  mode_e            mode,
  input  logic [CNT_W-1:0] cnt,
  output logic [PH_N-1:0]  phase
);
  localparam logic [CNT_W-1:0] B_PLL   = CNT_W'(PLL_TICKS);
  localparam logic [CNT_W-1:0] B_RXANA = CNT_W'(RXANA_TICKS);
  localparam logic [CNT_W-1:0] B_RXDAT = CNT_W'(RXDAT_TICKS);
  localparam logic [CNT_W-1:0] B_READY = CNT_W'(READY_TICKS);

  always_comb begin
    phase = '0;
    case (mode)
      M_HOLD: phase[PH_HOLD] = 1'b1;
      M_RST:  phase[PH_RST]  = 1'b1;
      default: begin
        if      (cnt < B_PLL)   phase[PH_BIAS]   = 1'b1;
        else if (cnt < B_RXANA) phase[PH_PLL]    = 1'b1;
        else if (cnt < B_RXDAT) phase[PH_RXANA]  = 1'b1;
        else if (cnt < B_READY) phase[PH_RXDATA] = 1'b1;
        else                    phase[PH_READY]  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
  import xps_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int HOLD_US      = 40,
  parameter int RST_MIN_US   = 1,
  parameter int PLL_US       = 32,
  parameter int RXANA_US     = 262,
  parameter int RXDATA_US    = 326,
  parameter int READY_US     = 358
) (
  input  logic        clk,
  input  logic        supply_ok,
  input  logic        rst_pin_n,
  input  logic        pll_bypass,
  input  logic        low_power,
  output logic        pll_force_min,
  output logic        serial_out_zero,
  output logic        rx_word_freeze,
  output logic        deser_clk_rst,
  output logic        phase_sel_clr,
  output logic        dfilt_clr,
  output logic        comma_det_en,
  output logic        rx_valid,
  output logic [6:0]  phase_onehot
);
  localparam int HOLD_T  = HOLD_US * TICKS_PER_US;
  localparam int RMIN_T  = RST_MIN_US * TICKS_PER_US;
  localparam int PLL_T   = PLL_US * TICKS_PER_US;
  localparam int RXANA_T = RXANA_US * TICKS_PER_US;
  localparam int RXDAT_T = RXDATA_US * TICKS_PER_US;
  localparam int READY_T = READY_US * TICKS_PER_US;
  localparam int MAX_T   = (HOLD_T > READY_T) ? HOLD_T : READY_T;
  localparam int CNT_W   = $clog2(MAX_T + 1);

  logic             sup_s;
  logic [2:0]       ctl_s;
  logic             acc;
  mode_e            mode;
  logic [CNT_W-1:0] cnt;
  logic [PH_N-1:0]  phase;
  logic             forced;

  xps_sync #(.W(1), .RST_VAL(1'b0)) u_sup_sync (
    .clk(clk), .arst_n(supply_ok), .d(1'b1), .q(sup_s));

  xps_sync #(.W(3), .RST_VAL(3'b100)) u_ctl_sync (
    .clk(clk), .arst_n(supply_ok),
    .d({rst_pin_n, pll_bypass, low_power}), .q(ctl_s));

  xps_rst_qual #(.MIN_TICKS(RMIN_T)) u_qual (
    .clk(clk), .arst_n(supply_ok), .low_s(!ctl_s[2]), .accepted(acc));

  xps_timeline #(.HOLD_TICKS(HOLD_T), .READY_TICKS(READY_T), .CNT_W(CNT_W)) u_tl (
    .clk(clk), .arst_n(supply_ok), .sup_s(sup_s),
    .gate(ctl_s[1] | ctl_s[0]), .acc(acc), .mode(mode), .cnt(cnt));

  xps_phase_dec #(.CNT_W(CNT_W), .PLL_TICKS(PLL_T), .RXANA_TICKS(RXANA_T),
                  .RXDAT_TICKS(RXDAT_T), .READY_TICKS(READY_T)) u_dec (
    .mode(mode), .cnt(cnt), .phase(phase));

  assign forced          = phase[PH_HOLD] | phase[PH_RST];
  assign pll_force_min   = forced | phase[PH_BIAS];
  assign serial_out_zero = forced;
  assign rx_word_freeze  = forced;
  assign deser_clk_rst   = forced;
  assign phase_sel_clr   = forced;
  assign dfilt_clr       = forced;
  assign comma_det_en    = phase[PH_READY];
  assign rx_valid        = phase[PH_READY];
  assign phase_onehot    = phase;

  // R10
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $countones(phase_onehot) == 1);

  // R3
  ready_order_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    (phase_onehot[PH_READY] && !$past(phase_onehot[PH_READY])) |->
      $past(phase_onehot[PH_RXDATA]));

  // R8
  rst_force_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    phase_onehot[PH_RST] |-> (serial_out_zero && pll_force_min && dfilt_clr &&
                              phase_sel_clr && !comma_det_en && !rx_valid));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    ($past(phase_onehot[PH_RST]) && !phase_onehot[PH_RST]) |-> phase_onehot[PH_BIAS]);

  // R5
  comma_gate_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    comma_det_en |-> (!pll_force_min && !serial_out_zero && rx_valid));
endmodule

// File: tb/xcvr_pwr_seq_test.sv
module xcvr_pwr_seq_test;
  localparam int T      = 4;
  localparam int HOLD   = 40 * T;
  localparam int RMIN   = 1 * T;
  localparam int B_PLL  = 32 * T;
  localparam int B_ANA  = 262 * T;
  localparam int B_DAT  = 326 * T;
  localparam int B_RDY  = 358 * T;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, rst_pin_n = 1'b1, pll_bypass = 1'b0, low_power = 1'b0;
  logic pll_force_min, serial_out_zero, rx_word_freeze, deser_clk_rst;
  logic phase_sel_clr, dfilt_clr, comma_det_en, rx_valid;
  logic [6:0] phase_onehot;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  xcvr_pwr_seq uut (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
    .pll_bypass(pll_bypass), .low_power(low_power),
    .pll_force_min(pll_force_min), .serial_out_zero(serial_out_zero),
    .rx_word_freeze(rx_word_freeze), .deser_clk_rst(deser_clk_rst),
    .phase_sel_clr(phase_sel_clr), .dfilt_clr(dfilt_clr),
    .comma_det_en(comma_det_en), .rx_valid(rx_valid), .phase_onehot(phase_onehot));

  function automatic logic [6:0] exp_run(input int n);
    if (n < B_PLL)      return 7'b0000100;
    else if (n < B_ANA) return 7'b0001000;
    else if (n < B_DAT) return 7'b0010000;
    else if (n < B_RDY) return 7'b0100000;
    else                return 7'b1000000;
  endfunction

  function automatic logic [7:0] exp_outs(input logic [6:0] ph);
    logic f;
    f = ph[0] | ph[1];
    return {f | ph[2], f, f, f, f, f, ph[6], ph[6]};
  endfunction

  function automatic bit exp_accept(input int len);
    return len >= RMIN;
  endfunction

  function automatic logic [7:0] outs();
    return {pll_force_min, serial_out_zero, rx_word_freeze, deser_clk_rst,
            phase_sel_clr, dfilt_clr, comma_det_en, rx_valid};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic chk_phase(input logic [6:0] ph, input string tag);
    chk(phase_onehot === ph, tag, int'(phase_onehot), int'(ph));
  endtask

  // Current negedge is n = 0 of a fresh timeline; walk it to ready.
  task automatic run_timeline();
    for (int k = 0; k <= B_RDY + 3; k++) begin
      if (k != 0) @(negedge clk);
      chk_phase(exp_run(k), "R3 timeline phase");
      chk(outs() === exp_outs(exp_run(k)), "R4/R5 outputs per phase",
          int'(outs()), int'(exp_outs(exp_run(k))));
    end
  endtask

  task automatic reset_pulse(input int len);
    bit a;
    a = exp_accept(len);
    @(negedge clk);
    rst_pin_n = 1'b0;
    for (int k = 1; k <= len + 6; k++) begin
      @(negedge clk);
      if (a) begin
        if (k < RMIN + 3)       chk_phase(7'b1000000, "R7 before acceptance");
        else if (k <= len + 3) begin
          chk_phase(7'b0000010, "R7/R8 reset phase");
          chk(outs() === 8'b11111100, "R8 forced outputs", int'(outs()), 8'hFC);
        end else if (k == len + 4) begin
          chk_phase(7'b0000100, "R9 restart at phase zero");
          if (k == len) rst_pin_n = 1'b1;
          run_timeline();
          return;
        end
      end else begin
        chk_phase(7'b1000000, "R7 short pulse ignored");
      end
      if (k == len) rst_pin_n = 1'b1;
    end
  endtask

  task automatic gate_test(input bit use_bypass);
    @(negedge clk);
    if (use_bypass) pll_bypass = 1'b1; else low_power = 1'b1;
    @(negedge clk); chk_phase(7'b1000000, "R6 gate latency n1");
    @(negedge clk); chk_phase(7'b1000000, "R6 gate latency n2");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk_phase(7'b0000100, "R6 parked at phase zero");
    end
    pll_bypass = 1'b0;
    low_power  = 1'b0;
    @(negedge clk); chk_phase(7'b0000100, "R6 release latency");
    @(negedge clk);
    run_timeline();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk_phase(7'b0000001, "R1 reset state phase");
    chk(outs() === 8'b11111100, "R1 reset state outputs", int'(outs()), 8'hFC);
    supply_ok = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (phase_onehot == 7'b0000001 && k < HOLD + 50);
    chk(k == HOLD + 2, "R2 hold length", k, HOLD + 2);
    chk_phase(7'b0000100, "R2 first phase after hold");
    run_timeline();

    reset_pulse(RMIN - 1);
    reset_pulse(RMIN);
    for (int i = 0; i < 8; i++) reset_pulse(1 + int'($urandom % (2 * RMIN + 2)));

    gate_test(1'b0);
    gate_test(1'b1);

    // R10: every phase walked above was compared as a full one-hot vector
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk_phase(7'b0000001, "R1 supply drop returns to hold");
    chk(outs() === 8'b11111100, "R1 supply drop outputs", int'(outs()), 8'hFC);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule